// File: doc/BRIEF.md
# Vector element loop sequencer

This block sits between instruction decode and issue. A vector-prefixed instruction enters once and leaves as a series of element operations, one per element, strictly in program order. Each element carries the operand register numbers. An operand marked as vector gets the current step index added to its base number. An operand marked as scalar keeps its base number. Elements are handed downstream on a valid/ready handshake. The step advances only when an element is accepted, so each element behaves like a separate sequential instruction.

The loop position lives in a 32-bit state register that acts as a sub-program-counter. An interrupt request is sampled only between element issues. When it is taken, the state is copied into a shadow register on the same edge that raises the exception pulse, which is when the surrounding core saves the PC and MSR. The restore pulse copies the state back, so a re-presented instruction resumes at the saved element. A prefixed instruction from a class that may not be extended raises an illegal-instruction exception. So does an element whose register number would run past the end of the register file. Two special-purpose registers expose the state and the shadow copy to register-move instructions.

Top module: `vec_step_seq`

## Requirements
- R1: The state register holds MVL in bits [6:0], VL in bits [13:7] and srcstep in bits [20:14]. Bits [31:21] always read zero. A read on `spr_num` 704 returns the state and 720 returns the shadow copy, one cycle after the number is applied. Any other number reads zero.
- R2: A write to number 704 or 720 whose VL field exceeds its MVL field stores VL equal to MVL.
- R3: A prefixed instruction issues elements with `el_step` running from srcstep up to VL-1, one per accepted handshake. `el_last` is high only on the final element.
- R4: For operand k (bits [7k+6:7k] of the register buses), a vector-marked operand reads base plus step and a scalar-marked operand reads base.
- R5: While `el_valid` is high and `el_ready` is low, the element outputs and srcstep hold their values.
- R6: A prefixed instruction accepted with VL = 0 issues no element, and `retire` pulses in the next cycle.
- R7: When the final element is accepted, `retire` pulses in the next cycle, `el_valid` falls, and srcstep returns to 0.
- R8: A non-prefixed instruction issues exactly one element with its base register numbers, step 0 and `el_last` high. The state register is left unchanged.
- R9: If `irq_req` is high when a non-final element is accepted, `el_valid` falls and `exc_take` pulses with `exc_illegal` low. The shadow copy receives the state with srcstep set to the next element, and the live srcstep is cleared.
- R10: A `restore` pulse copies the shadow copy into the state. The same instruction, presented again, starts at the saved step.
- R11: A prefixed instruction with `in_opclass` 1, 2, 3 or 4 (length-set, branch, MSR write, MSR read) pulses `exc_take` and `exc_illegal` and issues no element.
- R12: An element whose vector register number would exceed 127 is not issued. Instead `exc_take` and `exc_illegal` pulse, and the shadow copy records the offending step.
- R13: `in_ready` is low while an element loop is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Sequencer takes the instruction this cycle |
| in_prefixed | input | 1 | Instruction carries the vector prefix |
| in_opclass | input | 3 | Opcode class; 1 to 4 may not be prefixed |
| in_base | input | NUM_OPS*REG_W | Base register numbers, operand 0 in the low bits |
| in_isvec | input | NUM_OPS | Per-operand vector mark |
| el_valid | output | 1 | Element operation valid |
| el_ready | input | 1 | Issue stage accepts the element |
| el_regs | output | NUM_OPS*REG_W | Element register numbers |
| el_step | output | 7 | Element index |
| el_last | output | 1 | Final element of the instruction |
| retire | output | 1 | One-cycle pulse: instruction done, advance PC |
| irq_req | input | 1 | Interrupt request, sampled between elements |
| exc_take | output | 1 | One-cycle pulse: exception taken, save context |
| exc_illegal | output | 1 | Exception cause is illegal instruction |
| restore | input | 1 | Return-from-exception: restore the state |
| spr_we | input | 1 | Special register write strobe |
| spr_num | input | 10 | Special register number |
| spr_wdata | input | 32 | Special register write data |
| spr_rdata | output | 32 | Registered read data |
| svstate_o | output | 32 | Live loop state |

## Verification
A wrong step count inside the loop shows up on `el_regs` and `el_step` at the very next accepted element: vector operands drift off base plus index, and `el_last` arrives early or late. A state that is not cleared or saved correctly at an exception appears one cycle later, on `svstate_o` and on a read of the shadow number. After a restore it shows as the first re-issued element starting at the wrong index. Stall errors appear on the first cycle with `el_ready` low, as a changed element output.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int SV_W   = 32;
  localparam int FLD_W  = 7;
  localparam int RSV_W  = SV_W - 3 * FLD_W;
  localparam int OPC_W  = 3;
  localparam int SPRN_W = 10;

  localparam logic [SPRN_W-1:0] SPR_STATE  = 10'd704;
  localparam logic [SPRN_W-1:0] SPR_SHADOW = 10'd720;

  typedef struct packed {
    logic [RSV_W-1:0] rsv;
    logic [FLD_W-1:0] step;
    logic [FLD_W-1:0] vl;
    logic [FLD_W-1:0] mvl;
  } svstate_t;

  typedef enum logic [OPC_W-1:0] {
    OPC_ALU    = 3'd0,
    OPC_SETLEN = 3'd1,
    OPC_BRANCH = 3'd2,
    OPC_MSRWR  = 3'd3,
    OPC_MSRRD  = 3'd4,
    OPC_LOAD   = 3'd5,
    OPC_STORE  = 3'd6,
    OPC_SPRMV  = 3'd7
  } opclass_e;

  function automatic logic class_blocked(input logic [OPC_W-1:0] c);
    return (c == OPC_SETLEN) || (c == OPC_BRANCH) ||
           (c == OPC_MSRWR)  || (c == OPC_MSRRD);
  endfunction

  function automatic svstate_t sv_clean(input logic [SV_W-1:0] w);
    svstate_t s;
    s = svstate_t'(w);
    s.rsv = '0;
    if (s.vl > s.mvl) s.vl = s.mvl;
    return s;
  endfunction
endpackage

// File: rtl/vseq_regnum.sv
module vseq_regnum
  import vseq_pkg::*;
#(
  parameter int REG_W   = 7,
  parameter int NUM_OPS = 3,
  localparam int OPS_W  = NUM_OPS * REG_W,
  localparam int SUM_W  = ((REG_W > FLD_W) ? REG_W : FLD_W) + 1
) (
  input  logic [OPS_W-1:0]   base,
  input  logic [NUM_OPS-1:0] isvec,
  input  logic [FLD_W-1:0]   step,
  output logic [OPS_W-1:0]   regs,
  output logic               ovf
);
  logic [NUM_OPS-1:0] ovf_v;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(base[g*REG_W +: REG_W]) + (isvec[g] ? SUM_W'(step) : '0);
    assign regs[g*REG_W +: REG_W] = sum[REG_W-1:0];
    assign ovf_v[g] = |sum[SUM_W-1:REG_W];
  end

  assign ovf = |ovf_v;
endmodule

// File: rtl/vseq_spr.sv
module vseq_spr
  import vseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_en,
  input  logic              spr_we,
  input  logic [SPRN_W-1:0] spr_num,
  input  logic [SV_W-1:0]   spr_wdata,
  input  logic              step_we,
  input  logic [FLD_W-1:0]  step_val,
  input  logic              exc_save,
  input  logic [FLD_W-1:0]  exc_step,
  input  logic              restore_go,
  output svstate_t          state,
  output svstate_t          shadow,
  output logic [SV_W-1:0]   spr_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= '0;
      shadow <= '0;
    end else if (exc_save) begin
      shadow      <= state;
      shadow.step <= exc_step;
      state.step  <= '0;
    end else if (step_we) begin
      state.step <= step_val;
    end else if (restore_go) begin
      state <= shadow;
    end else if (sw_en && spr_we) begin
      if (spr_num == SPR_STATE)  state  <= sv_clean(spr_wdata);
      if (spr_num == SPR_SHADOW) shadow <= sv_clean(spr_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) spr_rdata <= '0;
    else if (spr_num == SPR_STATE)  spr_rdata <= state;
    else if (spr_num == SPR_SHADOW) spr_rdata <= shadow;
    else spr_rdata <= '0;
  end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int REG_W   = 7,
  parameter int NUM_OPS = 3,
  localparam int OPS_W  = NUM_OPS * REG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_prefixed,
  input  logic [OPC_W-1:0]   in_opclass,
  input  logic [OPS_W-1:0]   in_base,
  input  logic [NUM_OPS-1:0] in_isvec,
  output logic               in_ready,
  input  logic               el_ready,
  input  logic               irq_req,
  input  logic               restore_req,
  input  logic [FLD_W-1:0]   cur_vl,
  input  logic [FLD_W-1:0]   cur_step,
  input  logic [OPS_W-1:0]   rn_regs,
  input  logic               rn_ovf,
  output logic [OPS_W-1:0]   src_base,
  output logic [NUM_OPS-1:0] src_vec,
  output logic [FLD_W-1:0]   src_step,
  output logic               el_valid,
  output logic [OPS_W-1:0]   el_regs,
  output logic [FLD_W-1:0]   el_step,
  output logic               el_last,
  output logic               retire,
  output logic               exc_take,
  output logic               exc_illegal,
  output logic               step_we,
  output logic [FLD_W-1:0]   step_val,
  output logic               exc_save,
  output logic [FLD_W-1:0]   exc_step,
  output logic               restore_go,
  output logic               idle
);
  typedef enum logic {S_IDLE, S_RUN} st_e;
  st_e state, nxt_state;

  logic [OPS_W-1:0]   lat_base;
  logic [NUM_OPS-1:0] lat_vec;
  logic               lat_pref;
  logic [FLD_W-1:0]   nstep;
  logic               do_issue, issue_last, set_retire, set_exc, set_ill, drop;

  assign idle     = (state == S_IDLE);
  assign in_ready = idle && !irq_req && !restore_req;
  assign nstep    = el_step + FLD_W'(1);
  assign src_base = idle ? in_base : lat_base;
  assign src_vec  = idle ? (in_prefixed ? in_isvec : '0) : lat_vec;
  assign src_step = idle ? (in_prefixed ? cur_step : '0) : nstep;

  always_comb begin
    nxt_state  = state;
    step_we    = 1'b0;
    step_val   = '0;
    exc_save   = 1'b0;
    exc_step   = cur_step;
    restore_go = 1'b0;
    do_issue   = 1'b0;
    issue_last = 1'b0;
    set_retire = 1'b0;
    set_exc    = 1'b0;
    set_ill    = 1'b0;
    drop       = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (irq_req) begin
          exc_save = 1'b1;
          set_exc  = 1'b1;
        end else if (restore_req) begin
          restore_go = 1'b1;
        end else if (in_valid) begin
          if (in_prefixed && class_blocked(in_opclass)) begin
            exc_save = 1'b1;
            set_exc  = 1'b1;
            set_ill  = 1'b1;
          end else if (in_prefixed && (cur_vl == '0 || cur_step >= cur_vl)) begin
            set_retire = 1'b1;
            step_we    = 1'b1;
          end else if (rn_ovf) begin
            exc_save = 1'b1;
            set_exc  = 1'b1;
            set_ill  = 1'b1;
          end else begin
            do_issue   = 1'b1;
            issue_last = !in_prefixed ||
                         (({1'b0, cur_step} + (FLD_W+1)'(1)) == {1'b0, cur_vl});
            nxt_state  = S_RUN;
          end
        end
      end
      S_RUN: begin
        if (el_ready) begin
          if (el_last) begin
            drop       = 1'b1;
            set_retire = 1'b1;
            step_we    = lat_pref;
            nxt_state  = S_IDLE;
          end else if (irq_req || rn_ovf) begin
            drop      = 1'b1;
            exc_save  = 1'b1;
            exc_step  = nstep;
            set_exc   = 1'b1;
            set_ill   = !irq_req;
            nxt_state = S_IDLE;
          end else begin
            do_issue   = 1'b1;
            issue_last = (({1'b0, nstep} + (FLD_W+1)'(1)) == {1'b0, cur_vl});
            step_we    = 1'b1;
            step_val   = nstep;
          end
        end
      end
      default: nxt_state = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      el_valid    <= 1'b0;
      el_regs     <= '0;
      el_step     <= '0;
      el_last     <= 1'b0;
      retire      <= 1'b0;
      exc_take    <= 1'b0;
      exc_illegal <= 1'b0;
      lat_base    <= '0;
      lat_vec     <= '0;
      lat_pref    <= 1'b0;
    end else begin
      state       <= nxt_state;
      retire      <= set_retire;
      exc_take    <= set_exc;
      exc_illegal <= set_ill;
      if (do_issue) begin
        el_valid <= 1'b1;
        el_regs  <= rn_regs;
        el_step  <= src_step;
        el_last  <= issue_last;
      end else if (drop) begin
        el_valid <= 1'b0;
      end
      if (idle && do_issue) begin
        lat_base <= in_base;
        lat_vec  <= src_vec;
        lat_pref <= in_prefixed;
      end
    end
  end
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vseq_pkg::*;
#(
  parameter int REG_W   = 7,
  parameter int NUM_OPS = 3,
  localparam int OPS_W  = NUM_OPS * REG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_prefixed,
  input  logic [2:0]         in_opclass,
  input  logic [OPS_W-1:0]   in_base,
  input  logic [NUM_OPS-1:0] in_isvec,
  output logic               el_valid,
  input  logic               el_ready,
  output logic [OPS_W-1:0]   el_regs,
  output logic [6:0]         el_step,
  output logic               el_last,
  output logic               retire,
  input  logic               irq_req,
  output logic               exc_take,
  output logic               exc_illegal,
  input  logic               restore,
  input  logic               spr_we,
  input  logic [9:0]         spr_num,
  input  logic [31:0]        spr_wdata,
  output logic [31:0]        spr_rdata,
  output logic [31:0]        svstate_o
);
  svstate_t           state, shadow;
  logic [OPS_W-1:0]   src_base, rn_regs;
  logic [NUM_OPS-1:0] src_vec;
  logic [FLD_W-1:0]   src_step, step_val, exc_step;
  logic               rn_ovf, step_we, exc_save, restore_go, idle;

  vseq_regnum #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) u_regnum (
    .base(src_base), .isvec(src_vec), .step(src_step),
    .regs(rn_regs), .ovf(rn_ovf)
  );

  vseq_spr u_spr (
    .clk(clk), .rst(rst), .sw_en(idle), .spr_we(spr_we), .spr_num(spr_num),
    .spr_wdata(spr_wdata), .step_we(step_we), .step_val(step_val),
    .exc_save(exc_save), .exc_step(exc_step), .restore_go(restore_go),
    .state(state), .shadow(shadow), .spr_rdata(spr_rdata)
  );

  vseq_ctrl #(.REG_W(REG_W), .NUM_OPS(NUM_OPS)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_prefixed(in_prefixed),
    .in_opclass(in_opclass), .in_base(in_base), .in_isvec(in_isvec),
    .in_ready(in_ready), .el_ready(el_ready), .irq_req(irq_req),
    .restore_req(restore), .cur_vl(state.vl), .cur_step(state.step),
    .rn_regs(rn_regs), .rn_ovf(rn_ovf), .src_base(src_base), .src_vec(src_vec),
    .src_step(src_step), .el_valid(el_valid), .el_regs(el_regs),
    .el_step(el_step), .el_last(el_last), .retire(retire),
    .exc_take(exc_take), .exc_illegal(exc_illegal), .step_we(step_we),
    .step_val(step_val), .exc_save(exc_save), .exc_step(exc_step),
    .restore_go(restore_go), .idle(idle)
  );

  assign svstate_o = state;
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int OPS_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             el_valid,
  input logic             el_ready,
  input logic [OPS_W-1:0] el_regs,
  input logic [6:0]       el_step,
  input logic             el_last,
  input logic             retire,
  input logic             exc_take,
  input logic             exc_illegal,
  input logic [31:0]      svstate_o
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
    svstate_o[31:21] == 11'd0);

  assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
    el_valid && el_ready && !el_last |=>
      (el_valid && el_step == $past(el_step) + 7'd1) || exc_take);

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    el_valid && !el_ready |=>
      el_valid && $stable(el_regs) && $stable(el_step) && $stable(el_last));

  assert_last_retires_R7: assert property (@(posedge clk) disable iff (rst)
    el_valid && el_ready && el_last |=> retire && !el_valid);

  assert_no_retire_with_exc_R7: assert property (@(posedge clk) disable iff (rst)
    !(retire && exc_take));

  assert_exc_clears_step_R9: assert property (@(posedge clk) disable iff (rst)
    exc_take |-> svstate_o[20:14] == 7'd0 && !el_valid);

  assert_illegal_is_exc_R11: assert property (@(posedge clk) disable iff (rst)
    exc_illegal |-> exc_take);

  assert_ready_blocked_R13: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !el_valid);
endmodule

bind vec_step_seq vseq_checker #(.OPS_W(NUM_OPS * REG_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .el_valid(el_valid),
  .el_ready(el_ready), .el_regs(el_regs), .el_step(el_step),
  .el_last(el_last), .retire(retire), .exc_take(exc_take),
  .exc_illegal(exc_illegal), .svstate_o(svstate_o)
);

// File: tb/vec_step_seq_test.sv
module vec_step_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 0, in_prefixed = 0, el_ready = 0, irq_req = 0;
  logic        restore = 0, spr_we = 0;
  logic [2:0]  in_opclass = 0;
  logic [20:0] in_base = 0;
  logic [2:0]  in_isvec = 0;
  logic [9:0]  spr_num = 0;
  logic [31:0] spr_wdata = 0;
  logic        in_ready, el_valid, el_last, retire, exc_take, exc_illegal;
  logic [20:0] el_regs;
  logic [6:0]  el_step;
  logic [31:0] spr_rdata, svstate_o;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vec_step_seq uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_prefixed(in_prefixed), .in_opclass(in_opclass), .in_base(in_base),
    .in_isvec(in_isvec), .el_valid(el_valid), .el_ready(el_ready),
    .el_regs(el_regs), .el_step(el_step), .el_last(el_last), .retire(retire),
    .irq_req(irq_req), .exc_take(exc_take), .exc_illegal(exc_illegal),
    .restore(restore), .spr_we(spr_we), .spr_num(spr_num),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .svstate_o(svstate_o)
  );

  function automatic logic [31:0] mksv(input int step, input int vl, input int mvl);
    return {11'd0, 7'(step), 7'(vl), 7'(mvl)};
  endfunction

  function automatic logic [20:0] pk(input int a, input int b, input int c);
    return {7'(c), 7'(b), 7'(a)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic spr_write(input logic [9:0] num, input logic [31:0] d);
    @(negedge clk); spr_we = 1; spr_num = num; spr_wdata = d;
    @(negedge clk); spr_we = 0;
  endtask

  task automatic spr_read(input logic [9:0] num, output logic [31:0] d);
    @(negedge clk); spr_num = num;
    @(negedge clk); d = spr_rdata;
  endtask

  task automatic present(input logic p, input logic [2:0] c, input logic [20:0] b,
                         input logic [2:0] v);
    @(negedge clk);
    in_prefixed = p; in_opclass = c; in_base = b; in_isvec = v; in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", svstate_o, 0);
    chk("R13 reset in_ready", {31'd0, in_ready}, 1);
    chk("R3 reset el_valid", {31'd0, el_valid}, 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    spr_write(10'd704, mksv(2, 5, 10) | 32'hFFE0_0000);
    chk("R1 reserved bits dropped", svstate_o, mksv(2, 5, 10));
    spr_read(10'd704, d); chk("R1 read state", d, mksv(2, 5, 10));
    spr_read(10'd720, d); chk("R1 read shadow after reset", d, 0);
    spr_read(10'd300, d); chk("R1 read other number", d, 0);
  endtask

  task automatic t_clamp();
    spr_write(10'd704, mksv(0, 20, 8));
    chk("R2 vl clamped", svstate_o, mksv(0, 8, 8));
  endtask

  task automatic t_vector();
    spr_write(10'd704, mksv(0, 4, 8));
    el_ready = 1;
    present(1, 0, pk(10, 20, 30), 3'b101);
    for (int k = 0; k < 4; k++) begin
      chk("R3 valid", {31'd0, el_valid}, 1);
      chk("R3 step", {25'd0, el_step}, k);
      chk("R4 regs", {11'd0, el_regs}, {11'd0, pk(10 + k, 20, 30 + k)});
      chk("R3 last flag", {31'd0, el_last}, (k == 3) ? 1 : 0);
      chk("R13 busy", {31'd0, in_ready}, 0);
      @(negedge clk);
    end
    chk("R7 retire", {31'd0, retire}, 1);
    chk("R7 valid drop", {31'd0, el_valid}, 0);
    chk("R7 step back to zero", svstate_o, mksv(0, 4, 8));
  endtask

  task automatic t_stall();
    spr_write(10'd704, mksv(0, 3, 8));
    el_ready = 0;
    present(1, 0, pk(5, 6, 7), 3'b011);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 held regs", {11'd0, el_regs}, {11'd0, pk(5, 6, 7)});
      chk("R5 held step", {25'd0, el_step}, 0);
      chk("R5 srcstep held", svstate_o, mksv(0, 3, 8));
    end
    el_ready = 1;
    @(negedge clk);
    chk("R4 stall elem1", {11'd0, el_regs}, {11'd0, pk(6, 7, 7)});
    @(negedge clk);
    chk("R4 stall elem2", {11'd0, el_regs}, {11'd0, pk(7, 8, 7)});
    chk("R3 stall last", {31'd0, el_last}, 1);
    @(negedge clk);
    chk("R7 stall retire", {31'd0, retire}, 1);
  endtask

  task automatic t_vl0();
    spr_write(10'd704, mksv(0, 0, 8));
    el_ready = 1;
    present(1, 0, pk(1, 2, 3), 3'b111);
    chk("R6 retire", {31'd0, retire}, 1);
    chk("R6 no element", {31'd0, el_valid}, 0);
    chk("R6 no exception", {31'd0, exc_take}, 0);
    @(negedge clk);
    chk("R6 still no element", {31'd0, el_valid}, 0);
  endtask

  task automatic t_scalar();
    spr_write(10'd704, mksv(0, 4, 8));
    el_ready = 1;
    present(0, 0, pk(40, 41, 42), 3'b111);
    chk("R8 valid", {31'd0, el_valid}, 1);
    chk("R8 base regs", {11'd0, el_regs}, {11'd0, pk(40, 41, 42)});
    chk("R8 last", {31'd0, el_last}, 1);
    @(negedge clk);
    chk("R8 retire", {31'd0, retire}, 1);
    chk("R8 state unchanged", svstate_o, mksv(0, 4, 8));
  endtask

  task automatic t_irq();
    logic [31:0] d;
    spr_write(10'd704, mksv(0, 5, 8));
    el_ready = 1;
    present(1, 0, pk(50, 60, 70), 3'b010);
    @(negedge clk);
    chk("R4 irq elem1", {11'd0, el_regs}, {11'd0, pk(50, 61, 70)});
    irq_req = 1;
    @(negedge clk);
    irq_req = 0;
    chk("R9 exc_take", {31'd0, exc_take}, 1);
    chk("R9 cause", {31'd0, exc_illegal}, 0);
    chk("R9 valid drop", {31'd0, el_valid}, 0);
    chk("R9 live step cleared", svstate_o, mksv(0, 5, 8));
    spr_read(10'd720, d); chk("R9 shadow step", d, mksv(2, 5, 8));
    @(negedge clk); restore = 1;
    @(negedge clk); restore = 0;
    chk("R10 restored", svstate_o, mksv(2, 5, 8));
    present(1, 0, pk(50, 60, 70), 3'b010);
    for (int k = 2; k < 5; k++) begin
      chk("R10 resume step", {25'd0, el_step}, k);
      chk("R10 resume regs", {11'd0, el_regs}, {11'd0, pk(50, 60 + k, 70)});
      @(negedge clk);
    end
    chk("R7 resume retire", {31'd0, retire}, 1);
    chk("R7 resume step zero", svstate_o, mksv(0, 5, 8));
  endtask

  task automatic t_illegal();
    spr_write(10'd704, mksv(0, 4, 8));
    present(1, 3'd2, pk(1, 2, 3), 3'b000);
    chk("R11 branch exc", {30'd0, exc_take, exc_illegal}, 3);
    chk("R11 no element", {31'd0, el_valid}, 0);
    present(1, 3'd3, pk(1, 2, 3), 3'b000);
    chk("R11 msr write exc", {30'd0, exc_take, exc_illegal}, 3);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    spr_write(10'd704, mksv(0, 4, 8));
    el_ready = 1;
    present(1, 0, pk(126, 3, 4), 3'b001);
    chk("R12 elem0", {11'd0, el_regs}, {11'd0, pk(126, 3, 4)});
    @(negedge clk);
    chk("R12 elem1", {11'd0, el_regs}, {11'd0, pk(127, 3, 4)});
    @(negedge clk);
    chk("R12 exc", {30'd0, exc_take, exc_illegal}, 3);
    chk("R12 no element", {31'd0, el_valid}, 0);
    spr_read(10'd720, d); chk("R12 shadow step", d, mksv(2, 4, 8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_clamp();
    t_vector();
    t_stall();
    t_vl0();
    t_scalar();
    t_irq();
    t_illegal();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule